// File: doc/BRIEF.md
# Two-Step Flash Conversion Sequencer

This block is the digital controller of an 8-bit half-flash converter made of two 4-bit flash stages. The stages are modelled by two 4-bit result buses. The block watches an active-low select, write and read strobe and a mode strap. It drives the zero/compare phase of each stage, pulses a capture strobe as each nibble is stored, and presents the assembled byte with an output enable. It also drives an active-low interrupt and a busy flag.

With the strap low (read-driven mode), a read falling edge starts the conversion. The upper stage compares and the lower stage zeroes for one stage interval. The upper nibble is then stored and the lower stage compares for a second interval. After that the lower nibble is stored, the interrupt falls and the byte is driven. With the strap high (write-driven mode), write low holds the upper stage in compare and the lower stage in zero at the same time, so both see the input in one window. The write rising edge stores the upper nibble and starts the lower compare. The interrupt falls one stage interval later, or sooner if a read arrives after the early-read interval. Intervals are given in nanoseconds and converted to clock counts. Every strobe passes a two-flop synchronizer.

There is no valid/ready stream here. The result is a register that the host reads with the read strobe. It holds until the next conversion starts, so no back-pressure is needed.

Top module: `hf_conv_seq`

## Requirements
- R1: After reset both stages are in zero phase (`up_cmp`=0, `lo_cmp`=0), `int_n`=1, `busy`=0, `dout_oe`=0, `dout`=0, and both capture strobes are 0.
- R2: In read-driven mode (`mode_wr`=0), a read falling edge while selected sets `up_cmp`=1, `lo_cmp`=0 and `busy`=1 on the third rising clock edge after the strobe changes.
- R3: In read-driven mode, the upper phase lasts STAGE_C cycles and ends with a pulse on `up_lat` and `lo_cmp`=1. A second STAGE_C cycles later, `lo_lat` pulses, `busy`=0, `int_n`=0, and `dout` = {upper nibble sampled at the first capture, lower nibble sampled at the second}, upper nibble in bits 7:4.
- R4: In write-driven mode, a write falling edge while selected sets `up_cmp`=1 together with `lo_cmp`=0, and this holds for as long as write stays low.
- R5: In write-driven mode, the write rising edge stores the upper nibble, pulses `up_lat` and switches to `up_cmp`=0, `lo_cmp`=1.
- R6: With no read, `int_n` falls STAGE_C cycles after the lower phase begins. That is 3+STAGE_C clock edges after the write pin rises.
- R7: A read falling edge seen while the lower phase counter is at least EARLY_C ends the conversion at once: `int_n`=0 and the byte is driven on the next edge.
- R8: A read falling edge seen before EARLY_C cycles of the lower phase is ignored. The lower phase continues and `int_n` falls at the normal time.
- R9: Once `int_n` is low, a read rising edge or a select release returns the block to idle with `int_n`=1.
- R10: `dout_oe`=1 only while the result is complete (`int_n`=0) and the synchronized select and read are both low. Otherwise `dout`=0.
- R11: Write and read edges seen while select is high start nothing.
- R12: With select and read held low in write-driven mode, each write falling edge starts a new conversion, even from the completed state: `int_n` rises and the enable drops until the new result is ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low select |
| wr_n | input | 1 | Active-low write strobe |
| rd_n | input | 1 | Active-low read strobe |
| mode_wr | input | 1 | Mode strap: 1 write-driven, 0 read-driven |
| up_res | input | STAGE_W | Upper stage decoder result |
| lo_res | input | STAGE_W | Lower stage decoder result |
| up_cmp | output | 1 | Upper stage phase: 1 compare, 0 zero |
| lo_cmp | output | 1 | Lower stage phase: 1 compare, 0 zero |
| up_lat | output | 1 | Pulse: upper nibble stored |
| lo_lat | output | 1 | Pulse: lower nibble stored |
| dout | output | 2*STAGE_W | Result byte, zero when not enabled |
| dout_oe | output | 1 | Result output enable |
| int_n | output | 1 | Active-low conversion-complete interrupt |
| busy | output | 1 | High during a read-driven conversion |

## Verification
The bench targets the edge of the early-read window. A read 100 cycles into the lower phase must be ignored, and one at 160 cycles must end the conversion three edges later. A design with an off-by-one or a missing gate would raise the interrupt early or never honour the fast read. It checks that the upper nibble is stored at the phase switch and not at completion, by changing the result bus in between. It also checks that strobes with select high are dropped and that a write in the completed state restarts stand-alone operation. A design that got these wrong would drive stale data or sit forever with the interrupt low.

// File: rtl/hfc_pkg.sv
package hfc_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_UP,
    ST_RD_LO,
    ST_WR_SMP,
    ST_WR_LO,
    ST_DONE
  } seq_st_e;

  function automatic int unsigned ns_to_cyc(int unsigned ns, int unsigned per);
    return (ns + per - 1) / per;
  endfunction

endpackage

// File: rtl/hfc_sync.sv
module hfc_sync #(
  parameter int unsigned   W       = 4,
  parameter logic [W-1:0]  RST_VAL = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  for (genvar i = 0; i < W; i++) begin : g_bit
    logic m1;
    logic m2;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        m1 <= RST_VAL[i];
        m2 <= RST_VAL[i];
      end else begin
        m1 <= d[i];
        m2 <= m1;
      end
    end
    assign q[i] = m2;
  end

endmodule

// File: rtl/hfc_seq_fsm.sv
module hfc_seq_fsm
  import hfc_pkg::*;
#(
  parameter int unsigned EARLY_C = 150,
  parameter int unsigned STAGE_C = 200
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n_s,
  input  logic wr_n_s,
  input  logic rd_n_s,
  input  logic mode_s,
  output logic up_cmp,
  output logic lo_cmp,
  output logic cap_up,
  output logic cap_lo,
  output logic busy,
  output logic int_n
);

  localparam int unsigned CW = $clog2(STAGE_C + 1);
  localparam logic [CW-1:0] LAST_CNT  = CW'(STAGE_C - 1);
  localparam logic [CW-1:0] EARLY_CNT = CW'(EARLY_C);
  localparam logic [CW-1:0] SAT_CNT   = CW'(STAGE_C);

  seq_st_e       st, nxt;
  logic [CW-1:0] cnt;
  logic          cs_n_p, wr_n_p, rd_n_p;
  logic          sel, rd_fall, rd_rise, wr_fall, wr_rise, cs_rise;

  // previous synchronized strobe levels for edge detection
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_n_p <= 1'b1;
      wr_n_p <= 1'b1;
      rd_n_p <= 1'b1;
    end else begin
      cs_n_p <= cs_n_s;
      wr_n_p <= wr_n_s;
      rd_n_p <= rd_n_s;
    end
  end

  assign sel     = ~cs_n_s;
  assign rd_fall = sel & rd_n_p & ~rd_n_s;
  assign rd_rise = sel & ~rd_n_p & rd_n_s;
  assign wr_fall = sel & wr_n_p & ~wr_n_s;
  assign wr_rise = sel & ~wr_n_p & wr_n_s;
  assign cs_rise = ~cs_n_p & cs_n_s;

  always_comb begin
    nxt    = st;
    cap_up = 1'b0;
    cap_lo = 1'b0;
    unique case (st)
      ST_IDLE: begin
        if (!mode_s && rd_fall)     nxt = ST_RD_UP;
        else if (mode_s && wr_fall) nxt = ST_WR_SMP;
      end
      ST_RD_UP: begin
        if (cnt == LAST_CNT) begin
          nxt    = ST_RD_LO;
          cap_up = 1'b1;
        end
      end
      ST_RD_LO: begin
        if (cnt == LAST_CNT) begin
          nxt    = ST_DONE;
          cap_lo = 1'b1;
        end
      end
      ST_WR_SMP: begin
        if (wr_rise) begin
          nxt    = ST_WR_LO;
          cap_up = 1'b1;
        end
      end
      ST_WR_LO: begin
        if ((rd_fall && cnt >= EARLY_CNT) || cnt == LAST_CNT) begin
          nxt    = ST_DONE;
          cap_lo = 1'b1;
        end
      end
      ST_DONE: begin
        if (mode_s && wr_fall)          nxt = ST_WR_SMP;
        else if (!mode_s && rd_fall)    nxt = ST_RD_UP;
        else if (rd_rise || cs_rise)    nxt = ST_IDLE;
      end
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= ST_IDLE;
      cnt <= '0;
    end else begin
      st <= nxt;
      if (nxt != st)       cnt <= '0;
      else if (cnt != SAT_CNT) cnt <= cnt + 1'b1;
    end
  end

  assign up_cmp = (st == ST_RD_UP) || (st == ST_WR_SMP);
  assign lo_cmp = (st == ST_RD_LO) || (st == ST_WR_LO);
  assign busy   = (st == ST_RD_UP) || (st == ST_RD_LO);
  assign int_n  = (st != ST_DONE);

  AST_LO_FOLLOWS_UP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lo_cmp) |-> $past(cap_up)); // R5

  AST_INT_FOLLOWS_LO: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(int_n) |-> $past(cap_lo)); // R3

  AST_SAMPLE_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(up_cmp) |-> (!lo_cmp && int_n)); // R4

  AST_EARLY_RD_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_WR_LO && rd_fall && cnt < EARLY_CNT) |=> (int_n && lo_cmp)); // R8

  AST_DESELECT_NO_START: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_IDLE && cs_n_s) |=> (st == ST_IDLE)); // R11

endmodule

// File: rtl/hfc_result.sv
module hfc_result #(
  parameter int unsigned STAGE_W = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cap_up,
  input  logic                   cap_lo,
  input  logic [STAGE_W-1:0]     up_res,
  input  logic [STAGE_W-1:0]     lo_res,
  input  logic                   done,
  input  logic                   cs_n_s,
  input  logic                   rd_n_s,
  output logic [2*STAGE_W-1:0]   dout,
  output logic                   dout_oe,
  output logic                   up_lat,
  output logic                   lo_lat
);

  logic [STAGE_W-1:0] hi_q, lo_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q   <= '0;
      lo_q   <= '0;
      up_lat <= 1'b0;
      lo_lat <= 1'b0;
    end else begin
      if (cap_up) hi_q <= up_res;
      if (cap_lo) lo_q <= lo_res;
      up_lat <= cap_up;
      lo_lat <= cap_lo;
    end
  end

  assign dout_oe = done & ~cs_n_s & ~rd_n_s;
  assign dout    = dout_oe ? {hi_q, lo_q} : '0;

  AST_DATA_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (dout_oe && $past(dout_oe)) |-> $stable(dout)); // R10

  AST_LAT_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    up_lat |=> !up_lat); // R5

endmodule

// File: rtl/hf_conv_seq.sv
module hf_conv_seq #(
  parameter int unsigned CLK_PERIOD_NS = 4,
  parameter int unsigned T_EARLY_NS    = 600,
  parameter int unsigned T_STAGE_NS    = 800,
  parameter int unsigned STAGE_W       = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cs_n,
  input  logic                 wr_n,
  input  logic                 rd_n,
  input  logic                 mode_wr,
  input  logic [STAGE_W-1:0]   up_res,
  input  logic [STAGE_W-1:0]   lo_res,
  output logic                 up_cmp,
  output logic                 lo_cmp,
  output logic                 up_lat,
  output logic                 lo_lat,
  output logic [2*STAGE_W-1:0] dout,
  output logic                 dout_oe,
  output logic                 int_n,
  output logic                 busy
);

  localparam int unsigned EARLY_C = hfc_pkg::ns_to_cyc(T_EARLY_NS, CLK_PERIOD_NS);
  localparam int unsigned STAGE_C = hfc_pkg::ns_to_cyc(T_STAGE_NS, CLK_PERIOD_NS);

  logic [3:0] s_vec;
  logic       cap_up, cap_lo;

  hfc_sync #(.W(4), .RST_VAL(4'b0111)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({mode_wr, rd_n, wr_n, cs_n}),
    .q     (s_vec)
  );

  hfc_seq_fsm #(.EARLY_C(EARLY_C), .STAGE_C(STAGE_C)) u_fsm (
    .clk    (clk),
    .rst_n  (rst_n),
    .cs_n_s (s_vec[0]),
    .wr_n_s (s_vec[1]),
    .rd_n_s (s_vec[2]),
    .mode_s (s_vec[3]),
    .up_cmp (up_cmp),
    .lo_cmp (lo_cmp),
    .cap_up (cap_up),
    .cap_lo (cap_lo),
    .busy   (busy),
    .int_n  (int_n)
  );

  hfc_result #(.STAGE_W(STAGE_W)) u_res (
    .clk     (clk),
    .rst_n   (rst_n),
    .cap_up  (cap_up),
    .cap_lo  (cap_lo),
    .up_res  (up_res),
    .lo_res  (lo_res),
    .done    (~int_n),
    .cs_n_s  (s_vec[0]),
    .rd_n_s  (s_vec[2]),
    .dout    (dout),
    .dout_oe (dout_oe),
    .up_lat  (up_lat),
    .lo_lat  (lo_lat)
  );

  AST_BUSY_NOT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && !int_n)); // R3

endmodule

// File: tb/hf_conv_seq_tb_top.sv
module hf_conv_seq_tb_top;

  localparam int STAGE = 200;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       cs_n, wr_n, rd_n, mode_wr;
  logic [3:0] up_res, lo_res;
  logic       up_cmp, lo_cmp, up_lat, lo_lat, dout_oe, int_n, busy;
  logic [7:0] dout;

  int compared = 0;
  int mismatched = 0;
  int cyc = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  hf_conv_seq dut_i (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .wr_n(wr_n), .rd_n(rd_n),
    .mode_wr(mode_wr), .up_res(up_res), .lo_res(lo_res),
    .up_cmp(up_cmp), .lo_cmp(lo_cmp), .up_lat(up_lat), .lo_lat(lo_lat),
    .dout(dout), .dout_oe(dout_oe), .int_n(int_n), .busy(busy)
  );

  // reference model: phases 0 idle,1 read-upper,2 read-lower,3 write-sample,4 write-lower,5 done
  int       ph, t;
  bit [3:0] h1, h2, h3;   // {mode, rd_n, wr_n, cs_n} delay line
  bit [3:0] e_hi, e_lo;
  bit       e_ul, e_ll;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph = 0; t = 0; e_hi = 0; e_lo = 0; e_ul = 0; e_ll = 0;
      h1 = 4'b0111; h2 = 4'b0111; h3 = 4'b0111;
    end else begin
      bit sel, rdf, rdr, wrf, wrr, csr, md, cu, cl;
      int nph;
      sel = !h2[0];
      rdf = sel && h3[2] && !h2[2];
      rdr = sel && !h3[2] && h2[2];
      wrf = sel && h3[1] && !h2[1];
      wrr = sel && !h3[1] && h2[1];
      csr = !h3[0] && h2[0];
      md  = h2[3];
      nph = ph; cu = 0; cl = 0;
      case (ph)
        0: if (!md && rdf) nph = 1; else if (md && wrf) nph = 3;
        1: if (t == STAGE - 1) begin nph = 2; cu = 1; end
        2: if (t == STAGE - 1) begin nph = 5; cl = 1; end
        3: if (wrr) begin nph = 4; cu = 1; end
        4: if ((rdf && t >= 150) || t == STAGE - 1) begin nph = 5; cl = 1; end
        default: if (md && wrf) nph = 3; else if (!md && rdf) nph = 1;
                 else if (rdr || csr) nph = 0;
      endcase
      t  = (nph != ph) ? 0 : t + 1;
      ph = nph;
      if (cu) e_hi = up_res;
      if (cl) e_lo = lo_res;
      e_ul = cu; e_ll = cl;
      h3 = h2; h2 = h1; h1 = {mode_wr, rd_n, wr_n, cs_n};
    end
  end

  task automatic check(string req, string what, int act, int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s %s: actual %0h expected %0h at cycle %0d", req, what, act, exp, cyc);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (!finished) begin
      bit eoe;
      eoe = (ph == 5) && !h2[0] && !h2[2];
      check("R2",  "up_cmp",  up_cmp,  (ph == 1 || ph == 3));
      check("R5",  "lo_cmp",  lo_cmp,  (ph == 2 || ph == 4));
      check("R3",  "busy",    busy,    (ph == 1 || ph == 2));
      check("R6",  "int_n",   int_n,   (ph != 5));
      check("R10", "dout_oe", dout_oe, eoe);
      check("R3",  "dout",    dout,    eoe ? {e_hi, e_lo} : 8'h00);
      check("R5",  "up_lat",  up_lat,  e_ul);
      check("R3",  "lo_lat",  lo_lat,  e_ll);
    end
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary();
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !finished) begin
      mismatched++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      summary();
    end
  end

  initial begin
    int n;
    rst_n = 1'b0; cs_n = 1'b1; wr_n = 1'b1; rd_n = 1'b1; mode_wr = 1'b0;
    up_res = 4'h0; lo_res = 4'h0;
    tick(5);
    check("R1", "reset up_cmp", up_cmp, 0);
    check("R1", "reset lo_cmp", lo_cmp, 0);
    check("R1", "reset int_n", int_n, 1);
    check("R1", "reset busy", busy, 0);
    check("R1", "reset dout_oe", dout_oe, 0);
    check("R1", "reset dout", dout, 0);
    rst_n = 1'b1;
    tick(5);

    // R2 / R3: read-driven conversion
    cs_n = 1'b0; up_res = 4'hA; lo_res = 4'h3;
    tick(5);
    rd_n = 1'b0;
    tick(2);
    check("R2", "up_cmp before sync", up_cmp, 0);
    tick(1);
    check("R2", "up_cmp", up_cmp, 1);
    check("R2", "lo_cmp zero", lo_cmp, 0);
    check("R2", "busy", busy, 1);
    tick(199);
    check("R3", "lo_cmp before switch", lo_cmp, 0);
    tick(1);
    check("R3", "lo_cmp after switch", lo_cmp, 1);
    check("R3", "up_lat", up_lat, 1);
    tick(47);
    up_res = 4'h5; lo_res = 4'hC;
    tick(153);
    check("R3", "int_n", int_n, 0);
    check("R3", "busy end", busy, 0);
    check("R3", "dout", dout, 8'hAC);
    rd_n = 1'b1;
    tick(2);
    check("R10", "oe off read high", dout_oe, 0);
    check("R10", "dout zero", dout, 0);
    tick(1);
    check("R9", "int released by read", int_n, 1);
    tick(5);

    // R4 / R5 / R6 / R10: write-driven, interrupt path
    mode_wr = 1'b1; up_res = 4'h6; lo_res = 4'h9;
    tick(5);
    wr_n = 1'b0;
    tick(3);
    check("R4", "up_cmp", up_cmp, 1);
    check("R4", "lo_cmp zero", lo_cmp, 0);
    tick(20);
    check("R4", "held up_cmp", up_cmp, 1);
    check("R4", "held lo_cmp", lo_cmp, 0);
    wr_n = 1'b1;
    n = 0;
    do begin @(negedge clk); n++; end while (int_n && n < 1000);
    check("R6", "int delay", n, 3 + STAGE);
    check("R10", "oe off before read", dout_oe, 0);
    rd_n = 1'b0;
    tick(3);
    check("R10", "oe on", dout_oe, 1);
    check("R10", "dout", dout, 8'h69);
    rd_n = 1'b1;
    tick(5);

    // R7: fast read after the early interval
    up_res = 4'h2; lo_res = 4'h7;
    wr_n = 1'b0; tick(10); wr_n = 1'b1;
    tick(160);
    rd_n = 1'b0;
    tick(2);
    check("R7", "int before", int_n, 1);
    tick(1);
    check("R7", "int at once", int_n, 0);
    check("R7", "dout", dout, 8'h27);
    rd_n = 1'b1;
    tick(5);

    // R8: premature read is ignored
    up_res = 4'h4; lo_res = 4'h1;
    wr_n = 1'b0; tick(10); wr_n = 1'b1;
    tick(100);
    rd_n = 1'b0;
    tick(20);
    check("R8", "int still high", int_n, 1);
    check("R8", "lower still comparing", lo_cmp, 1);
    tick(82);
    check("R8", "int at 202", int_n, 1);
    tick(1);
    check("R8", "int at 203", int_n, 0);
    check("R8", "dout", dout, 8'h41);
    rd_n = 1'b1;
    tick(5);

    // R9: select release clears interrupt
    wr_n = 1'b0; tick(10); wr_n = 1'b1;
    tick(250);
    check("R9", "int low", int_n, 0);
    cs_n = 1'b1;
    tick(2);
    check("R9", "int before release", int_n, 0);
    tick(1);
    check("R9", "int released by select", int_n, 1);
    tick(5);

    // R11: strobes while deselected
    wr_n = 1'b0; tick(10);
    check("R11", "no sample", up_cmp, 0);
    wr_n = 1'b1; tick(300);
    check("R11", "no interrupt", int_n, 1);
    check("R11", "no lower phase", lo_cmp, 0);
    mode_wr = 1'b0; tick(5);
    rd_n = 1'b0; tick(10);
    check("R11", "no busy", busy, 0);
    rd_n = 1'b1; tick(5);

    // R12: stand-alone restart
    mode_wr = 1'b1; rd_n = 1'b0; tick(2); cs_n = 1'b0;
    up_res = 4'h8; lo_res = 4'hE;
    tick(5);
    wr_n = 1'b0; tick(5); wr_n = 1'b1;
    tick(210);
    check("R12", "first int", int_n, 0);
    check("R12", "first oe", dout_oe, 1);
    check("R12", "first dout", dout, 8'h8E);
    up_res = 4'h3; lo_res = 4'h5;
    wr_n = 1'b0; tick(3);
    check("R12", "restart int", int_n, 1);
    check("R12", "restart oe", dout_oe, 0);
    check("R12", "restart sample", up_cmp, 1);
    tick(5); wr_n = 1'b1;
    tick(210);
    check("R12", "second dout", dout, 8'h35);
    rd_n = 1'b1; cs_n = 1'b1;
    tick(5);

    summary();
  end

endmodule